// File: doc/BRIEF.md
# Iterative 6k±1 Primality Tester

This block decides whether an 8-bit unsigned value is prime. A single-cycle start pulse loads the operand. A screening cycle then settles the small values and the multiples of 2 and 3. Any value that gets past the screen goes through trial division, one step per clock. Each step tests one divisor pair: d and d+2, where d = 6k−1 and the index k starts at 1. A one-cycle ready pulse ends the run, and a prime flag gives the verdict.

By design, 0 and 1 are both reported as prime. The flag keeps its verdict until the next accepted start, so a consumer can pick it up at any time after the ready pulse. The unit handles one operand at a time. While a test is running, start is ignored.

Top module: `prime_6k_tester`

## Requirements
- R1: While the synchronous active-high reset is sampled high, ready and prime are driven to 0 on the next clock edge, and any test in progress is abandoned.
- R2: Operands 0 and 1 are reported prime (prime = 1).
- R3: Operands 2 and 3 are reported prime.
- R4: Any other operand that is divisible by 2 or by 3 is reported not prime (prime = 0).
- R5: Every other operand goes through trial steps with k = 1, 2, ... and d = 6k−1. A step finishes the test as prime when d exceeds operand/d (integer quotient). Otherwise it finishes as not prime when d or d+2 divides the operand exactly, and if neither does, the next step follows.
- R6: Count the clock edge that samples start in the idle state as edge 0. For operands decided by the screen (R2–R4), ready is high after edge 1. For operands that finish at trial step j, ready is high after edge 1+j.
- R7: Ready is high for exactly one cycle per accepted start.
- R8: An accepted start clears prime to 0 at edge 0. Otherwise prime changes only on the edge that raises ready, and it holds its verdict until the next accepted start.
- R9: A start that arrives while a test is in progress is ignored. The result and its timing belong to the operand that was captured first.
- R10: For all 256 operand values, the verdict equals a reference that applies R2–R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Loads operand and begins a test when idle |
| operand | input | 8 | Unsigned value to test |
| ready | output | 1 | One-cycle pulse when the verdict is valid |
| prime | output | 1 | Verdict: 1 = prime (0 and 1 included), 0 = not prime |

## Verification
Screened operands are due one edge after the capture edge. Trial operands are due 1+j edges after it, where j is the index of the finishing step. The bench model computes j for each operand on its own. The bench changes inputs only at falling edges and samples ready and prime there as well. It counts falling edges from capture and compares the count at which ready first appears against 1+j. It then checks on the next falling edge that ready has dropped while prime keeps its value. Starts injected during trial steps must leave both the verdict and the edge count unchanged.

// File: rtl/prime6k_pkg.sv
package prime6k_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCREEN,
        ST_TRIAL
    } tst_state_e;

    typedef enum logic [1:0] {
        SCR_PRIME,
        SCR_COMPOSITE,
        SCR_TRIAL
    } screen_verdict_e;

    typedef struct packed {
        logic done;
        logic is_prime;
    } step_verdict_t;

endpackage

// File: rtl/prime_screen.sv
module prime_screen
    import prime6k_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] value,
    output screen_verdict_e verdict
);
    localparam logic [OP_W-1:0] C_ZERO  = '0;
    localparam logic [OP_W-1:0] C_TWO   = OP_W'(2);
    localparam logic [OP_W-1:0] C_THREE = OP_W'(3);
    localparam logic [OP_W-1:0] C_FOUR  = OP_W'(4);

    always_comb begin
        if (value < C_FOUR) begin
            // 0 and 1 are taken as prime by convention; 2 and 3 are prime
            verdict = SCR_PRIME;
        end else if ((value % C_TWO) == C_ZERO || (value % C_THREE) == C_ZERO) begin
            verdict = SCR_COMPOSITE;
        end else begin
            verdict = SCR_TRIAL;
        end
    end
endmodule

// File: rtl/prime_trial_step.sv
module prime_trial_step
    import prime6k_pkg::*;
#(
    parameter int OP_W = 8,
    parameter int D_W  = OP_W + 3
) (
    input  logic [OP_W-1:0] value,
    input  logic [D_W-1:0]  div,
    output step_verdict_t   verdict
);
    localparam logic [D_W-1:0] C_ZERO = '0;
    localparam logic [D_W-1:0] C_ONE  = D_W'(1);
    localparam logic [D_W-1:0] C_TWO  = D_W'(2);

    logic [D_W-1:0] val_ext;
    logic [D_W-1:0] safe_div;
    logic [D_W-1:0] quot;
    logic [D_W-1:0] rem_lo;
    logic [D_W-1:0] rem_hi;

    assign val_ext  = D_W'(value);
    // divisor is always at least 5 in use; guard keeps the operators defined
    assign safe_div = (div == C_ZERO) ? C_ONE : div;
    assign quot     = val_ext / safe_div;
    assign rem_lo   = val_ext % safe_div;
    assign rem_hi   = val_ext % (safe_div + C_TWO);

    always_comb begin
        if (safe_div > quot) begin
            verdict = '{done: 1'b1, is_prime: 1'b1};
        end else if (rem_lo == C_ZERO || rem_hi == C_ZERO) begin
            verdict = '{done: 1'b1, is_prime: 1'b0};
        end else begin
            verdict = '{done: 1'b0, is_prime: 1'b0};
        end
    end
endmodule

// File: rtl/prime_6k_tester.sv
module prime_6k_tester
    import prime6k_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] operand,
    output logic            ready,
    output logic            prime
);
    localparam int D_W = OP_W + 3;
    localparam logic [D_W-1:0]  C_SIX   = D_W'(6);
    localparam logic [D_W-1:0]  C_ONE   = D_W'(1);
    localparam logic [OP_W-1:0] IDX_ONE = OP_W'(1);

    tst_state_e      state_q;
    logic [OP_W-1:0] opnd_q;
    logic [OP_W-1:0] idx_q;
    logic [D_W-1:0]  div_w;
    logic            busy_w;
    screen_verdict_e scr_w;
    step_verdict_t   step_w;

    assign div_w  = (C_SIX * D_W'(idx_q)) - C_ONE;
    assign busy_w = (state_q != ST_IDLE);

    prime_screen #(.OP_W(OP_W)) u_screen (
        .value   (opnd_q),
        .verdict (scr_w)
    );

    prime_trial_step #(.OP_W(OP_W), .D_W(D_W)) u_step (
        .value   (opnd_q),
        .div     (div_w),
        .verdict (step_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            opnd_q  <= '0;
            idx_q   <= IDX_ONE;
            ready   <= 1'b0;
            prime   <= 1'b0;
        end else begin
            ready <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        opnd_q  <= operand;
                        prime   <= 1'b0;
                        state_q <= ST_SCREEN;
                    end
                end
                ST_SCREEN: begin
                    case (scr_w)
                        SCR_PRIME: begin
                            ready   <= 1'b1;
                            prime   <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        SCR_COMPOSITE: begin
                            ready   <= 1'b1;
                            prime   <= 1'b0;
                            state_q <= ST_IDLE;
                        end
                        default: begin
                            idx_q   <= IDX_ONE;
                            state_q <= ST_TRIAL;
                        end
                    endcase
                end
                ST_TRIAL: begin
                    if (step_w.done) begin
                        ready   <= 1'b1;
                        prime   <= step_w.is_prime;
                        state_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_ONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prime_6k_checks.sv
module prime_6k_checks #(
    parameter int OP_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            ready,
    input logic            prime,
    input logic            busy,
    input logic [OP_W-1:0] n_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!ready && !prime));

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R8
    prime_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (ready || $stable(prime)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(n_q));

    // R2
    low_prime_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && n_q < OP_W'(2)) |-> prime);

    // R3
    two_three_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && (n_q == OP_W'(2) || n_q == OP_W'(3))) |-> prime);

    // R4
    even_comp_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !n_q[0] && n_q > OP_W'(2)) |-> !prime);
endmodule

bind prime_6k_tester prime_6k_checks #(.OP_W(OP_W)) u_checks (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ready (ready),
    .prime (prime),
    .busy  (busy_w),
    .n_q   (opnd_q)
);

// File: tb/prime_6k_tester_test.sv
module prime_6k_tester_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] operand = '0;
    logic       ready;
    logic       prime;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prime_6k_tester uut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .operand (operand),
        .ready   (ready),
        .prime   (prime)
    );

    function automatic int ref_steps(int n);
        int d;
        int j;
        if (n < 4 || n % 2 == 0 || n % 3 == 0) return 0;
        d = 5;
        j = 1;
        forever begin
            if (d > n / d) return j;
            if (n % d == 0 || n % (d + 2) == 0) return j;
            d += 6;
            j++;
        end
    endfunction

    function automatic int ref_prime(int n);
        int d;
        if (n < 4) return 1;
        if (n % 2 == 0 || n % 3 == 0) return 0;
        d = 5;
        forever begin
            if (d > n / d) return 1;
            if (n % d == 0 || n % (d + 2) == 0) return 0;
            d += 6;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one test; with inject set, a competing start is held across a trial edge.
    task automatic run_one(input int v, input bit inject, input int other, input string req);
        int exp_lat;
        int seen;
        exp_lat = 1 + ref_steps(v);
        seen = 0;
        @(negedge clk);
        start = 1'b1;
        operand = 8'(v);
        @(negedge clk);              // edge 0 has captured the operand
        start = 1'b0;
        operand = 8'(other);
        chk(prime == 1'b0, "R8 clear on start", int'(prime), 0);
        for (int m = 1; m <= 8; m++) begin
            @(negedge clk);
            if (inject && m == 1 && exp_lat > 1) start = 1'b1;
            else start = 1'b0;
            if (ready) begin
                seen = m;
                break;
            end
        end
        start = 1'b0;
        chk(seen == exp_lat, (inject ? "R9 latency" : "R6 latency"), seen, exp_lat);
        chk(int'(prime) == ref_prime(v), req, int'(prime), ref_prime(v));
        @(negedge clk);
        chk(ready == 1'b0, "R7 ready single cycle", int'(ready), 0);
        chk(int'(prime) == ref_prime(v), "R8 verdict held", int'(prime), ref_prime(v));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
        chk(prime == 1'b0, "R1 prime in reset", int'(prime), 0);
        rst = 1'b0;

        // directed corners
        run_one(0, 1'b0, 0, "R2 zero");
        run_one(1, 1'b0, 0, "R2 one");
        run_one(2, 1'b0, 0, "R3 two");
        run_one(3, 1'b0, 0, "R3 three");
        run_one(4, 1'b0, 0, "R4 four");
        run_one(9, 1'b0, 0, "R4 nine");
        run_one(254, 1'b0, 0, "R4 254");
        run_one(5, 1'b0, 0, "R5 five");
        run_one(25, 1'b0, 0, "R5 25");
        run_one(49, 1'b0, 0, "R5 49");
        run_one(121, 1'b0, 0, "R5 121");
        run_one(143, 1'b0, 0, "R5 143");
        run_one(169, 1'b0, 0, "R5 169");
        run_one(221, 1'b0, 0, "R5 221");
        run_one(251, 1'b0, 0, "R5 251");

        // busy start ignored: competitor is a screened value with a different verdict
        run_one(251, 1'b1, 4, "R9 verdict kept 251");
        run_one(25, 1'b1, 2, "R9 verdict kept 25");
        run_one(169, 1'b1, 1, "R9 verdict kept 169");

        // reset mid-test
        @(negedge clk);
        start = 1'b1;
        operand = 8'd251;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0, "R1 mid-test ready", int'(ready), 0);
        chk(prime == 1'b0, "R1 mid-test prime", int'(prime), 0);
        rst = 1'b0;
        run_one(7, 1'b0, 0, "R1 recovery after reset");

        // constrained random, some with competing starts
        for (int i = 0; i < 40; i++) begin
            int v;
            int o;
            v = int'($urandom % 256);
            o = int'($urandom % 256);
            run_one(v, ($urandom % 2) == 1, o, "R5 random");
        end

        // exhaustive
        for (int v = 0; v < 256; v++) begin
            run_one(v, 1'b0, 0, "R10 exhaustive");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule